// File: doc/BRIEF.md
# Set-acknowledge toggle switch

A clocked one-bit state holder driven through two request/response handshakes. A request on the toggle port flips the stored level and is answered by an acknowledge pulse. A request on the query port leaves the level alone and is answered by a pulse on one of two response wires: one wire for the off level, the other for the on level. The caller therefore learns the state from which wire fires, not from a data value.

Each handshake is strictly sequential. The caller issues one request and waits for its response before it issues the next. A response is a single-cycle pulse that appears one clock after the request is sampled. The block flags a protocol breach in a sticky error bit and otherwise ignores the request that caused it. A breach is either of two things: a request in the same cycle as a visible response, or both requests in the same cycle. The current level is also available on a status pin.

Top module: `sw_toggle_switch`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, level_o, ack_o, on_o, off_o and err_o are all 0. Level 0 means off.
- R2: A toggle request is accepted when set_i is high in a cycle where read_i is low and no response output is high. At the next clock edge an accepted toggle inverts level_o and raises ack_o.
- R3: A query request is accepted when read_i is high in a cycle where set_i is low and no response output is high. With level_o at 0, an accepted query raises off_o at the next edge and keeps on_o low. level_o is unchanged.
- R4: With level_o at 1, an accepted query raises on_o at the next edge and keeps off_o low. level_o is unchanged.
- R5: Each of ack_o, on_o and off_o is high for exactly one cycle per accepted request. No two of them are high together.
- R6: A request (set_i or read_i) in a cycle where any response output is high sets err_o at the next edge. That request produces no response and does not change level_o.
- R7: set_i and read_i high in the same cycle set err_o at the next edge. They produce no response and do not change level_o.
- R8: Once set, err_o stays high until reset. Legal requests are still served normally while it is set.
- R9: Pulling rst_ni low clears level_o, err_o and any response output at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Toggle request pulse |
| read_i | input | 1 | Query request pulse |
| ack_o | output | 1 | Toggle acknowledge pulse |
| on_o | output | 1 | Query answer: level is on |
| off_o | output | 1 | Query answer: level is off |
| level_o | output | 1 | Current stored level |
| err_o | output | 1 | Sticky protocol breach flag |

## Verification
A wrong stored level shows up on the very next query: the answer fires on the opposite response wire one cycle after the query. It is also visible at once on level_o. A missed or doubled toggle, or a request that should have been rejected but was not, shows up within one cycle as a wrong or extra pulse. The next query then confirms it. An error flag that does not hold its value, or that is not raised on a breach, shows up one cycle after the offending input pattern. The bench drives every four-step sequence of the four input codes from reset. Every sequence is compared cycle by cycle against an arithmetic model.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic {
    SW_OFF = 1'b0,
    SW_ON  = 1'b1
  } sw_level_e;

  typedef struct packed {
    logic tog;
    logic rd;
  } sw_cmd_t;
endpackage

// File: rtl/sw_req_filter.sv
module sw_req_filter
  import sw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    set_i,
  input  logic    read_i,
  input  logic    busy_i,
  output sw_cmd_t cmd_o,
  output logic    err_o
);
  logic collide, early, err_q;

  assign collide = set_i & read_i;
  assign early   = (set_i | read_i) & busy_i;

  always_comb begin
    cmd_o     = '0;
    cmd_o.tog = set_i  & ~read_i & ~busy_i;
    cmd_o.rd  = read_i & ~set_i  & ~busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              err_q <= 1'b0;
    else if (collide | early) err_q <= 1'b1;
  end
  assign err_o = err_q;

  a_r7_collide_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && read_i) |=> err_o);
  a_r6_early_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i || read_i) && busy_i) |=> err_o);
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/sw_state_reg.sv
module sw_state_reg
  import sw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tog_i,
  output sw_level_e level_o
);
  sw_level_e level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    level_q <= SW_OFF;
    else if (tog_i) level_q <= (level_q == SW_ON) ? SW_OFF : SW_ON;
  end
  assign level_o = level_q;

  a_r2_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_i |=> (level_o != $past(level_o)));
  a_r3_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tog_i |=> $stable(level_o));
endmodule

// File: rtl/sw_resp_gen.sv
module sw_resp_gen
  import sw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sw_cmd_t   cmd_i,
  input  sw_level_e level_i,
  output logic      ack_o,
  output logic      on_o,
  output logic      off_o,
  output logic      busy_o
);
  logic ack_q, on_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      ack_q <= cmd_i.tog;
      on_q  <= cmd_i.rd & (level_i == SW_ON);
      off_q <= cmd_i.rd & (level_i == SW_OFF);
    end
  end

  assign ack_o  = ack_q;
  assign on_o   = on_q;
  assign off_o  = off_q;
  assign busy_o = ack_q | on_q | off_q;

  a_r5_onehot_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_o, on_o, off_o}));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
endmodule

// File: rtl/sw_toggle_switch.sv
module sw_toggle_switch
  import sw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic read_i,
  output logic ack_o,
  output logic on_o,
  output logic off_o,
  output logic level_o,
  output logic err_o
);
  sw_cmd_t   cmd;
  sw_level_e level;
  logic      busy;

  sw_req_filter u_filter (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(set_i), .read_i(read_i),
    .busy_i(busy), .cmd_o(cmd), .err_o(err_o)
  );

  sw_state_reg u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .tog_i(cmd.tog), .level_o(level)
  );

  sw_resp_gen u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .level_i(level),
    .ack_o(ack_o), .on_o(on_o), .off_o(off_o), .busy_o(busy)
  );

  assign level_o = (level == SW_ON);

  a_r3_off_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !set_i && !(ack_o || on_o || off_o) && !level_o) |=> (off_o && !on_o && !level_o));
  a_r4_on_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !set_i && !(ack_o || on_o || off_o) && level_o) |=> (on_o && !off_o && level_o));
  a_r6_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i || read_i) && (ack_o || on_o || off_o)) |=> (!ack_o && !on_o && !off_o && $stable(level_o)));
  a_r7_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && read_i) |=> (!ack_o && !on_o && !off_o && $stable(level_o)));
endmodule

// File: tb/sw_toggle_switch_bench.sv
module sw_toggle_switch_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0, set_i = 1'b0, read_i = 1'b0;
  logic ack_o, on_o, off_o, level_o, err_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  logic m_level, m_err, m_ack, m_on, m_off, m_err_prev;

  always #10 clk_i = ~clk_i;

  sw_toggle_switch u_sw_toggle_switch (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .read_i(read_i),
    .ack_o(ack_o), .on_o(on_o), .off_o(off_o), .level_o(level_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_level = 0; m_err = 0; m_ack = 0; m_on = 0; m_off = 0; m_err_prev = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; set_i = 1'b0; read_i = 1'b0;
    model_reset();
    #1;
    chk("R1 level in reset", level_o, 1'b0);
    chk("R1 err in reset", err_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 level after reset", level_o, 1'b0);
    chk("R1 resp after reset", ack_o | on_o | off_o, 1'b0);
    chk("R1 err after reset", err_o, 1'b0);
  endtask

  // drive one cycle at negedge, advance model, compare at next negedge
  task automatic step(input logic s, input logic r);
    logic busy, acc_s, acc_r;
    set_i = s; read_i = r;
    busy  = m_ack | m_on | m_off;
    acc_s = s & ~r & ~busy;
    acc_r = r & ~s & ~busy;
    m_err_prev = m_err;
    if ((s & r) | ((s | r) & busy)) m_err = 1'b1;
    m_ack = acc_s;
    m_on  = acc_r & m_level;
    m_off = acc_r & ~m_level;
    m_level = m_level ^ acc_s;
    @(negedge clk_i);
    set_i = 1'b0; read_i = 1'b0;
    chk("R2 ack", ack_o, m_ack);
    chk("R2 level", level_o, m_level);
    chk("R3 off answer", off_o, m_off);
    chk("R4 on answer", on_o, m_on);
    chk("R5 one response", ($countones({ack_o, on_o, off_o}) <= 1), 1'b1);
    if (m_err_prev) chk("R8 err sticky", err_o, m_err);
    else if (s & r) chk("R7 collide err", err_o, m_err);
    else            chk("R6 early err", err_o, m_err);
  endtask

  initial begin
    model_reset();
    do_reset();
    // exhaustive four-step sequences of codes {idle,set,read,both}
    for (int seq = 0; seq < 256; seq++) begin
      do_reset();
      for (int k = 0; k < 4; k++) begin
        int code;
        code = (seq >> (2 * k)) & 3;
        step(code[0], code[1]);
      end
      step(1'b0, 1'b0);
    end
    // directed: toggle, query on, toggle back, query off
    do_reset();
    step(1, 0); step(0, 0); step(0, 1); chk("R4 on seen", m_on, 1'b1);
    step(0, 0); step(1, 0); step(0, 0); step(0, 1); chk("R3 off seen", m_off, 1'b1);
    step(0, 0);
    // R9: asynchronous reset while ack is high
    step(1, 0);
    rst_ni = 1'b0;
    #1;
    chk("R9 ack cleared async", ack_o, 1'b0);
    chk("R9 level cleared async", level_o, 1'b0);
    chk("R9 err cleared async", err_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule